// File: doc/BRIEF.md
# Zero-Crossing Gated Stereo Wiper Update

This block sits between a volume controller and the tap-select registers of a stereo pair of attenuator ladders. When the controller presents a new tap index, the block takes it and holds it as a pending target. It then moves each channel's wiper register to that target at a quiet moment in that channel's audio, so that the switch does not cause a click.

A quiet moment is marked by a change of a one-bit sign input, one per channel. The sign input comes from an analog comparator outside this block and is asynchronous to the clock. Each channel commits on its own crossing, independently of the other. A window counter bounds the wait: any channel that has not seen a crossing when the window closes is committed at that point.

A busy flag covers the whole span from acceptance to the last commit. New targets are refused while it is set.

Top module: `zc_wiper_commit`

## Requirements
- R1: While reset is held, and after it is released until a target is accepted, both tap outputs equal RESET_TAP (default 10) and busy is 0.
- R2: A target is accepted on a clock edge where tgt_valid is 1 and busy is 0. busy reads 1 after that edge, and neither tap output changes on that edge.
- R3: Each sign input passes through a two-register synchronizer. A crossing is a difference between the two most recent synchronized samples. A sign value first sampled at edge i that differs from the value sampled at edge i-1 commits a waiting channel at edge i+2.
- R4: The left and right channels commit independently. A crossing on one channel updates only that channel's tap output.
- R5: A channel still waiting TIMEOUT edges after the accepting edge is committed on that edge (edge a+TIMEOUT for acceptance at edge a), whatever its sign input does.
- R6: busy stays 1 until both channels have committed. It drops on the edge of the last commit, and at that point both tap outputs hold the accepted target.
- R7: tgt_valid while busy is 1 is ignored. The pending target is unchanged, and no second update follows.
- R8: While busy is 0, sign changes have no effect on either tap output.
- R9: Tap indices are unsigned TAP_W-bit values (0 to 31 by default). Both end values, 0 and 31, commit like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| tgt_valid | input | 1 | New target tap index offered |
| tgt_tap | input | TAP_W | Offered target tap index |
| sign_l | input | 1 | Left channel comparator sign, asynchronous |
| sign_r | input | 1 | Right channel comparator sign, asynchronous |
| tap_l | output | TAP_W | Registered left wiper tap index |
| tap_r | output | TAP_W | Registered right wiper tap index |
| busy | output | 1 | A target is accepted and at least one channel has not committed |

## Verification
The assertions take for granted that tgt_valid and tgt_tap are steady across each clock edge. They also assume that the controller treats busy as a refusal, so any offer it makes while busy is discarded rather than queued. The window bound holds because acceptance can never coincide with the edge where busy drops.

The bench changes every input at the falling edge, so each one is stable at the rising edge. It keeps sign changes during reset-synchronizer release out of the stimulus. It also offers targets while busy, to show that they are dropped.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_WAIT = 1'b1
  } ch_state_e;
endpackage

// File: rtl/zcw_rst_sync.sv
module zcw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/zcw_zc_detect.sv
module zcw_zc_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sign_i,
  output logic zc_o
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], sign_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // change between the two newest synchronized samples
  assign zc_o = pipe_q[STAGES-1] ^ pipe_q[STAGES];
endmodule

// File: rtl/zcw_window_timer.sv
module zcw_window_timer #(
  parameter int TIMEOUT = 3_200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = run_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      if (!at_last) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/zcw_channel.sv
module zcw_channel
  import zcw_pkg::*;
#(
  parameter int TAP_W     = 5,
  parameter int RESET_TAP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TAP_W-1:0] target_i,
  input  logic             zc_i,
  input  logic             expire_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             pend_o
);
  ch_state_e        state_q;
  ch_state_e        state_d;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] tap_d;
  logic             tap_en;
  logic             commit;

  assign commit = (state_q == CH_WAIT) && (zc_i || expire_i);

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    tap_en  = 1'b0;
    if (load_i) begin
      state_d = CH_WAIT;
    end else if (commit) begin
      state_d = CH_IDLE;
      tap_d   = target_i;
      tap_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      tap_q   <= TAP_W'(RESET_TAP);
    end else begin
      state_q <= state_d;
      if (tap_en) begin
        tap_q <= tap_d;
      end
    end
  end

  assign tap_o  = tap_q;
  assign pend_o = (state_q == CH_WAIT);
endmodule

// File: rtl/zc_wiper_commit.sv
module zc_wiper_commit
  import zcw_pkg::*;
#(
  parameter int TAP_W     = 5,
  parameter int RESET_TAP = 10,
  parameter int TIMEOUT   = 3_200_000,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_valid,
  input  logic [TAP_W-1:0] tgt_tap,
  input  logic             sign_l,
  input  logic             sign_r,
  output logic [TAP_W-1:0] tap_l,
  output logic [TAP_W-1:0] tap_r,
  output logic             busy
);
  logic             rst_sync_n;
  logic             accept;
  logic             expire;
  logic [TAP_W-1:0] tgt_q;
  logic [TAP_W-1:0] tgt_d;
  logic             tgt_en;

  logic             sign_vec [NUM_CH];
  logic             zc_vec   [NUM_CH];
  logic             pend_vec [NUM_CH];
  logic [TAP_W-1:0] tap_vec  [NUM_CH];

  zcw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign busy   = pend_vec[0] | pend_vec[1];
  assign accept = tgt_valid && !busy;

  always_comb begin
    tgt_en = accept;
    tgt_d  = tgt_tap;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_q <= TAP_W'(RESET_TAP);
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  zcw_window_timer #(
    .TIMEOUT (TIMEOUT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (accept),
    .run_i    (busy),
    .expire_o (expire)
  );

  assign sign_vec[0] = sign_l;
  assign sign_vec[1] = sign_r;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    zcw_zc_detect #(
      .STAGES (SYNC_STG)
    ) u_zc (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sign_i (sign_vec[ch]),
      .zc_o   (zc_vec[ch])
    );

    zcw_channel #(
      .TAP_W     (TAP_W),
      .RESET_TAP (RESET_TAP)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load_i   (accept),
      .target_i (tgt_q),
      .zc_i     (zc_vec[ch]),
      .expire_i (expire),
      .tap_o    (tap_vec[ch]),
      .pend_o   (pend_vec[ch])
    );
  end

  assign tap_l = tap_vec[0];
  assign tap_r = tap_vec[1];
endmodule

// File: rtl/zcw_checker.sv
module zcw_checker #(
  parameter int TAP_W   = 5,
  parameter int TIMEOUT = 3_200_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tgt_valid,
  input logic             busy,
  input logic [TAP_W-1:0] tap_l,
  input logic [TAP_W-1:0] tap_r
);
  localparam int MON_W = $clog2(TIMEOUT + 1) + 1;

  logic [MON_W-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (busy) begin
      if (win_cnt != '1) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end else begin
      win_cnt <= '0;
    end
  end

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tgt_valid) |=> busy); // R2

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win_cnt < MON_W'(TIMEOUT))); // R5

  AST_BOTH_MATCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tap_l == tap_r)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(tap_l) && $stable(tap_r))); // R8
endmodule

bind zc_wiper_commit zcw_checker #(
  .TAP_W   (TAP_W),
  .TIMEOUT (TIMEOUT)
) u_zcw_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tgt_valid (tgt_valid),
  .busy      (busy),
  .tap_l     (tap_l),
  .tap_r     (tap_r)
);

// File: tb/zc_wiper_commit_bench.sv
module zc_wiper_commit_bench;
  localparam int TAP_W     = 5;
  localparam int RESET_TAP = 10;
  localparam int TIMEOUT   = 40;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tgt_valid;
  logic [TAP_W-1:0] tgt_tap;
  logic             sign_l;
  logic             sign_r;
  logic [TAP_W-1:0] tap_l;
  logic [TAP_W-1:0] tap_r;
  logic             busy;

  always #5 clk = ~clk;

  zc_wiper_commit #(
    .TAP_W     (TAP_W),
    .RESET_TAP (RESET_TAP),
    .TIMEOUT   (TIMEOUT)
  ) u_zc_wiper_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_valid (tgt_valid),
    .tgt_tap   (tgt_tap),
    .sign_l    (sign_l),
    .sign_r    (sign_r),
    .tap_l     (tap_l),
    .tap_r     (tap_r),
    .busy      (busy)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    done    = 1'b0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: sampled sign queues, pending flags, window count
  int m_tap  [2];
  bit m_pend [2];
  int m_tgt;
  int m_cnt;
  bit sq_l [$];
  bit sq_r [$];
  bit m_busy;
  bit m_exp;
  bit m_zc [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tap  = '{RESET_TAP, RESET_TAP};
      m_pend = '{1'b0, 1'b0};
      m_tgt  = RESET_TAP;
      m_cnt  = 0;
      sq_l   = '{1'b0, 1'b0, 1'b0};
      sq_r   = '{1'b0, 1'b0, 1'b0};
    end else begin
      m_busy = m_pend[0] || m_pend[1];
      m_exp  = m_busy && (m_cnt == TIMEOUT - 1);
      // crossing visible now: samples taken two and three edges ago differ
      m_zc[0] = sq_l[1] != sq_l[0];
      m_zc[1] = sq_r[1] != sq_r[0];
      for (int c = 0; c < 2; c++) begin
        if (m_pend[c] && (m_zc[c] || m_exp)) begin
          m_tap[c]  = m_tgt;
          m_pend[c] = 1'b0;
        end
      end
      if (!m_busy && tgt_valid) begin
        m_tgt  = int'(tgt_tap);
        m_pend = '{1'b1, 1'b1};
        m_cnt  = 0;
      end else if (m_busy) begin
        m_cnt++;
      end else begin
        m_cnt = 0;
      end
      sq_l.push_back(sign_l);
      void'(sq_l.pop_front());
      sq_r.push_back(sign_r);
      void'(sq_r.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(cur_req, int'(tap_l), m_tap[0], "model tap_l");
      check(cur_req, int'(tap_r), m_tap[1], "model tap_r");
      check(cur_req, int'(busy), int'(m_pend[0] || m_pend[1]), "model busy");
    end
  end

  task automatic offer(input int tap);
    @(negedge clk);
    tgt_valid = 1'b1;
    tgt_tap   = TAP_W'(tap);
    @(negedge clk);
    tgt_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    tgt_valid = 1'b0;
    tgt_tap   = '0;
    sign_l    = 1'b0;
    sign_r    = 1'b0;
    wait_cyc(3);
    check("R1", int'(tap_l), RESET_TAP, "tap_l in reset");
    check("R1", int'(tap_r), RESET_TAP, "tap_r in reset");
    check("R1", int'(busy), 0, "busy in reset");
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1", int'(tap_l), RESET_TAP, "tap_l after release");

    // R5: no crossings, forced commit at edge a+TIMEOUT
    cur_req = "R5";
    offer(20);
    check("R2", int'(busy), 1, "busy after accept");
    check("R2", int'(tap_l), RESET_TAP, "tap_l unchanged on accept");
    wait_cyc(TIMEOUT - 1);
    check("R5", int'(tap_l), RESET_TAP, "tap_l one edge before window end");
    check("R5", int'(busy), 1, "busy one edge before window end");
    wait_cyc(1);
    check("R5", int'(tap_l), 20, "tap_l at window end");
    check("R5", int'(tap_r), 20, "tap_r at window end");
    check("R6", int'(busy), 0, "busy drops with last commit");

    // R3 R4 R6: left crosses first, right later
    cur_req = "R3";
    wait_cyc(3);
    offer(5);
    sign_l = 1'b1;
    wait_cyc(2);
    check("R3", int'(tap_l), 20, "tap_l before synchronizer latency");
    wait_cyc(1);
    check("R3", int'(tap_l), 5, "tap_l after left crossing");
    check("R4", int'(tap_r), 20, "tap_r untouched by left crossing");
    check("R6", int'(busy), 1, "busy while right pending");
    sign_r = 1'b1;
    wait_cyc(3);
    check("R4", int'(tap_r), 5, "tap_r after right crossing");
    check("R6", int'(busy), 0, "busy after both commit");

    // R7: offer while busy is dropped
    cur_req = "R7";
    wait_cyc(3);
    offer(12);
    tgt_valid = 1'b1;
    tgt_tap   = TAP_W'(30);
    wait_cyc(1);
    tgt_valid = 1'b0;
    wait_cyc(TIMEOUT + 2);
    check("R7", int'(tap_l), 12, "tap_l keeps first target");
    check("R7", int'(tap_r), 12, "tap_r keeps first target");
    check("R7", int'(busy), 0, "no second update");

    // R8: crossings while idle
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin
      sign_l = ~sign_l;
      if (k[0]) sign_r = ~sign_r;
      wait_cyc(2);
    end
    wait_cyc(4);
    check("R8", int'(tap_l), 12, "tap_l idle crossings");
    check("R8", int'(tap_r), 12, "tap_r idle crossings");

    // R9: top value, both channels cross together
    cur_req = "R9";
    offer(31);
    sign_l = ~sign_l;
    sign_r = ~sign_r;
    wait_cyc(3);
    check("R9", int'(tap_l), 31, "tap_l top value");
    check("R9", int'(tap_r), 31, "tap_r top value");
    check("R6", int'(busy), 0, "busy after joint commit");

    // R9: bottom value via window expiry
    wait_cyc(4);
    offer(0);
    wait_cyc(TIMEOUT);
    check("R9", int'(tap_l), 0, "tap_l bottom value");
    check("R9", int'(tap_r), 0, "tap_r bottom value");

    wait_cyc(4);
    finish_run();
  end
endmodule